// File: doc/BRIEF.md
# PCIe Root Port Link Bring-Up Sequencer

This block steps a root port through the configuration that comes before link training and then watches training until it finishes. When an accepted start request arrives and the link is not already active, it opens the write guard on the read-only configuration fields. It then places the requested maximum speed in the capability word and in the second link control word, and closes the guard again. After that it turns on training and polls a 5-bit training state input. The poll ends either when that input shows the active state or when a millisecond-scale time limit runs out.

The result appears on sticky flags: link up, timeout, or already active. These flags stay as they are until the next accepted start. On success the block also latches the negotiated speed and lane width from a link status word and sets a speed-change request bit. Each configuration step takes exactly one clock cycle. The physical layer and the real training logic are outside this block; the training state and the status word reach it as inputs.

Top module: `link_bringup_seq`

## Requirements
- R1: After reset, busy, link-up, timeout, already-up, the unlock bit and the training enable read 0. Speed and width read 0, and the capability, control-2 and width/speed words hold their reset parameter values, with bit 17 of the width/speed word cleared.
- R2: For a configuring start, the unlock bit (`ro_wen_o`) is high for exactly three consecutive cycles. The capability word and the control-2 word change only in the cycle after one in which the unlock bit was high.
- R3: A configuring start replaces bits [3:0] of both the capability word and the control-2 word with the target speed (1 = Gen1, 2 = Gen2, 3 = Gen3). Bits [31:4] of both words keep their previous values.
- R4: A target speed of 0 or above MAX_GEN is written as MAX_GEN.
- R5: The training enable goes high one cycle after the unlock bit falls. It drops in the cycle after a timeout is flagged, and it drops on any accepted start.
- R6: Link-up is declared only when the training state input equals 5'h11; neighbouring codes such as 5'h10 and 5'h12 do not count. At that moment the speed output takes bits [19:16] of the status word and the width output takes bits [23:20].
- R7: The wait for link-up allows TMO_CYC = CLK_HZ/1000*TIMEOUT_MS cycles, counted from the first cycle in which training is enabled. The active state seen in the last of those cycles still counts as link-up; if it is not seen by then, timeout is flagged.
- R8: A start while the training state already equals 5'h11 sets already-up and performs no configuration. The unlock bit and the training enable stay low, and the capability word stays unchanged.
- R9: The link-up, timeout and already-up flags hold until the next accepted start clears them. Link-up and timeout are never high together, and a start while busy is ignored.
- R10: On link-up, bit 17 of the width/speed control word is set. An accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled when idle |
| tgt_speed_i | input | 4 | Requested maximum speed |
| ltssm_i | input | 5 | Training state from the link controller |
| link_stat_i | input | 32 | Link status word |
| busy_o | output | 1 | Sequence in progress |
| link_up_o | output | 1 | Sticky: link reached the active state |
| timeout_o | output | 1 | Sticky: wait for link-up expired |
| already_up_o | output | 1 | Sticky: link was active at start |
| cur_speed_o | output | 4 | Latched negotiated speed |
| cur_width_o | output | 4 | Latched negotiated width |
| ro_wen_o | output | 1 | Read-only field write guard (bit 0 of misc control) |
| cap_word_o | output | 32 | Link capability word |
| ctl2_word_o | output | 32 | Link control 2 word |
| train_en_o | output | 1 | Training enable (bit 0 of command/status) |
| wsc_word_o | output | 32 | Width/speed control word; bit 17 requests a speed change |

## Verification
The sequence is exercised with several patterns:
- Each legal target speed, plus out-of-range targets of 0 and 15. These show the clamping apart from plain passing through.
- The active state arriving early, and arriving in the last allowed wait cycle or one cycle later. These separate success from timeout exactly at the window edge.
- Neighbouring training codes held for the whole wait. These show that only the exact active code counts.
- A start with the link already active, and a second start during the wait. These check that configuration is skipped or not restarted.

// File: rtl/lbu_pkg.sv
package lbu_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_UNLOCK, ST_WCAP, ST_WCTL2, ST_LOCK,
    ST_ENABLE, ST_WAIT, ST_UP, ST_FAIL
  } lbu_state_e;

  localparam logic [4:0] LTSSM_ACTIVE = 5'h11;
  localparam int SPEED_LSB  = 16;
  localparam int WIDTH_LSB  = 20;
  localparam int SPDCHG_BIT = 17;

  function automatic logic [3:0] clamp_speed(input logic [3:0] req,
                                             input logic [3:0] max_gen);
    return (req == 4'd0 || req > max_gen) ? max_gen : req;
  endfunction
endpackage

// File: rtl/lbu_regs.sv
module lbu_regs #(
  parameter logic [31:0] CAP_RESET  = 32'h0000_0003,
  parameter logic [31:0] CTL2_RESET = 32'h0000_0003,
  parameter logic [31:0] WSC_RESET  = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        unlock_i,
  input  logic        lock_i,
  input  logic        wr_cap_i,
  input  logic        wr_ctl2_i,
  input  logic [3:0]  speed_i,
  input  logic        set_train_i,
  input  logic        clr_train_i,
  input  logic        set_spdchg_i,
  input  logic        clr_spdchg_i,
  output logic        ro_wen_o,
  output logic [31:0] cap_o,
  output logic [31:0] ctl2_o,
  output logic        train_o,
  output logic [31:0] wsc_o
);
  import lbu_pkg::*;

  localparam logic [31:0] WSC_INIT = WSC_RESET & ~(32'h1 << SPDCHG_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      ro_wen_o <= 1'b0;
      cap_o    <= CAP_RESET;
      ctl2_o   <= CTL2_RESET;
      train_o  <= 1'b0;
      wsc_o    <= WSC_INIT;
    end else begin
      if (unlock_i)      ro_wen_o <= 1'b1;
      else if (lock_i)   ro_wen_o <= 1'b0;
      // read-only fields accept writes only while the guard is open
      if (wr_cap_i && ro_wen_o)  cap_o  <= {cap_o[31:4], speed_i};
      if (wr_ctl2_i && ro_wen_o) ctl2_o <= {ctl2_o[31:4], speed_i};
      if (clr_train_i)      train_o <= 1'b0;
      else if (set_train_i) train_o <= 1'b1;
      if (clr_spdchg_i)      wsc_o[SPDCHG_BIT] <= 1'b0;
      else if (set_spdchg_i) wsc_o[SPDCHG_BIT] <= 1'b1;
    end
  end
endmodule

// File: rtl/lbu_wait_timer.sv
module lbu_wait_timer #(
  parameter int TMO_CYC = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic hit_o
);
  localparam int CW = $clog2(TMO_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/lbu_fsm.sv
module lbu_fsm #(
  parameter logic [3:0] MAX_GEN = 4'd3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  input  logic [3:0]  tgt_i,
  input  logic [4:0]  ltssm_i,
  input  logic [31:0] stat_i,
  input  logic        tmo_hit_i,
  output logic        busy_o,
  output logic        up_o,
  output logic        to_o,
  output logic        already_o,
  output logic [3:0]  speed_o,
  output logic [3:0]  width_o,
  output logic [3:0]  tgt_q_o,
  output logic        acc_start_o,
  output logic        unlock_o,
  output logic        lock_o,
  output logic        wr_cap_o,
  output logic        wr_ctl2_o,
  output logic        set_train_o,
  output logic        fail_o,
  output logic        set_spdchg_o,
  output logic        wait_o
);
  import lbu_pkg::*;

  lbu_state_e st_q;
  logic       active;

  assign active = (ltssm_i == LTSSM_ACTIVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      up_o      <= 1'b0;
      to_o      <= 1'b0;
      already_o <= 1'b0;
      speed_o   <= '0;
      width_o   <= '0;
      tgt_q_o   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          up_o      <= 1'b0;
          to_o      <= 1'b0;
          speed_o   <= '0;
          width_o   <= '0;
          already_o <= active;
          if (!active) begin
            tgt_q_o <= clamp_speed(tgt_i, MAX_GEN);
            st_q    <= ST_UNLOCK;
          end
        end
        ST_UNLOCK: st_q <= ST_WCAP;
        ST_WCAP:   st_q <= ST_WCTL2;
        ST_WCTL2:  st_q <= ST_LOCK;
        ST_LOCK:   st_q <= ST_ENABLE;
        ST_ENABLE: st_q <= ST_WAIT;
        ST_WAIT: begin
          if (active) begin
            up_o    <= 1'b1;
            speed_o <= stat_i[SPEED_LSB +: 4];
            width_o <= stat_i[WIDTH_LSB +: 4];
            st_q    <= ST_UP;
          end else if (tmo_hit_i) begin
            to_o <= 1'b1;
            st_q <= ST_FAIL;
          end
        end
        ST_UP:   st_q <= ST_IDLE;
        ST_FAIL: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy_o       = (st_q != ST_IDLE);
    acc_start_o  = (st_q == ST_IDLE) && start_i;
    unlock_o     = (st_q == ST_UNLOCK);
    wr_cap_o     = (st_q == ST_WCAP);
    wr_ctl2_o    = (st_q == ST_WCTL2);
    lock_o       = (st_q == ST_LOCK);
    set_train_o  = (st_q == ST_ENABLE);
    wait_o       = (st_q == ST_WAIT);
    set_spdchg_o = (st_q == ST_UP);
    fail_o       = (st_q == ST_FAIL);
  end
endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq #(
  parameter int          CLK_HZ     = 125_000_000,
  parameter int          TIMEOUT_MS = 100,
  parameter logic [3:0]  MAX_GEN    = 4'd3,
  parameter logic [31:0] CAP_RESET  = 32'h0000_0003,
  parameter logic [31:0] CTL2_RESET = 32'h0000_0003,
  parameter logic [31:0] WSC_RESET  = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  input  logic [3:0]  tgt_speed_i,
  input  logic [4:0]  ltssm_i,
  input  logic [31:0] link_stat_i,
  output logic        busy_o,
  output logic        link_up_o,
  output logic        timeout_o,
  output logic        already_up_o,
  output logic [3:0]  cur_speed_o,
  output logic [3:0]  cur_width_o,
  output logic        ro_wen_o,
  output logic [31:0] cap_word_o,
  output logic [31:0] ctl2_word_o,
  output logic        train_en_o,
  output logic [31:0] wsc_word_o
);
  localparam int TMO_CYC = (CLK_HZ / 1000) * TIMEOUT_MS;

  logic [3:0] tgt_q;
  logic acc_start, unlock, lock, wr_cap, wr_ctl2, set_train, fail, set_spdchg;
  logic wait_st, tmo_hit;

  lbu_fsm #(.MAX_GEN(MAX_GEN)) u_fsm (
    .clk(clk), .rst(rst), .start_i(start_i), .tgt_i(tgt_speed_i),
    .ltssm_i(ltssm_i), .stat_i(link_stat_i), .tmo_hit_i(tmo_hit),
    .busy_o(busy_o), .up_o(link_up_o), .to_o(timeout_o),
    .already_o(already_up_o), .speed_o(cur_speed_o), .width_o(cur_width_o),
    .tgt_q_o(tgt_q), .acc_start_o(acc_start), .unlock_o(unlock),
    .lock_o(lock), .wr_cap_o(wr_cap), .wr_ctl2_o(wr_ctl2),
    .set_train_o(set_train), .fail_o(fail), .set_spdchg_o(set_spdchg),
    .wait_o(wait_st)
  );

  lbu_wait_timer #(.TMO_CYC(TMO_CYC)) u_tmr (
    .clk(clk), .rst(rst), .run_i(wait_st), .hit_o(tmo_hit)
  );

  lbu_regs #(
    .CAP_RESET(CAP_RESET), .CTL2_RESET(CTL2_RESET), .WSC_RESET(WSC_RESET)
  ) u_regs (
    .clk(clk), .rst(rst), .unlock_i(unlock), .lock_i(lock),
    .wr_cap_i(wr_cap), .wr_ctl2_i(wr_ctl2), .speed_i(tgt_q),
    .set_train_i(set_train), .clr_train_i(fail || acc_start),
    .set_spdchg_i(set_spdchg), .clr_spdchg_i(acc_start),
    .ro_wen_o(ro_wen_o), .cap_o(cap_word_o), .ctl2_o(ctl2_word_o),
    .train_o(train_en_o), .wsc_o(wsc_word_o)
  );
endmodule

// File: rtl/lbu_checker.sv
module lbu_checker (
  input logic        clk,
  input logic        rst,
  input logic        start_i,
  input logic [3:0]  tgt_speed_i,
  input logic [4:0]  ltssm_i,
  input logic [31:0] link_stat_i,
  input logic        busy_o,
  input logic        link_up_o,
  input logic        timeout_o,
  input logic        already_up_o,
  input logic [3:0]  cur_speed_o,
  input logic [3:0]  cur_width_o,
  input logic        ro_wen_o,
  input logic [31:0] cap_word_o,
  input logic [31:0] ctl2_word_o,
  input logic        train_en_o,
  input logic [31:0] wsc_word_o
);
  p_cap_gate_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(cap_word_o) |-> $past(ro_wen_o));
  p_ctl2_gate_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctl2_word_o) |-> $past(ro_wen_o));
  p_train_drop_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_o) |=> !train_en_o);
  p_up_active_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(link_up_o) |-> $past(ltssm_i) == 5'h11);
  p_skip_conf_r8: assert property (@(posedge clk) disable iff (rst)
    already_up_o |-> (!ro_wen_o && !train_en_o));
  p_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    !(link_up_o && timeout_o));
  p_spdchg_up_r10: assert property (@(posedge clk) disable iff (rst)
    wsc_word_o[17] |-> link_up_o);
endmodule

bind link_bringup_seq lbu_checker u_chk (.*);

// File: tb/link_bringup_seq_tb_top.sv
module link_bringup_seq_tb_top;
  localparam logic [31:0] CAP_R  = 32'hA5C3_7E90;
  localparam logic [31:0] CTL2_R = 32'h0000_0F21;
  localparam logic [31:0] WSC_R  = 32'h0001_010F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [3:0]  tgt_speed_i = '0;
  logic [4:0]  ltssm_i = 5'h03;
  logic [31:0] link_stat_i = '0;
  logic        busy_o, link_up_o, timeout_o, already_up_o, ro_wen_o, train_en_o;
  logic [3:0]  cur_speed_o, cur_width_o;
  logic [31:0] cap_word_o, ctl2_word_o, wsc_word_o;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  link_bringup_seq #(
    .CLK_HZ(200_000), .TIMEOUT_MS(1), .MAX_GEN(4'd3),
    .CAP_RESET(CAP_R), .CTL2_RESET(CTL2_R), .WSC_RESET(WSC_R)
  ) dut_i (.*);

  typedef struct packed {
    logic [3:0]  tgt;
    logic [4:0]  lt;
    logic [15:0] dly;
    logic [31:0] stat;
    logic        exp_up;
    logic [3:0]  exp_nib;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{4'd2,  5'h11, 16'd3,   32'h0042_0000, 1'b1, 4'd2},
    '{4'd1,  5'h11, 16'd0,   32'h0011_0000, 1'b1, 4'd1},
    '{4'd3,  5'h11, 16'd199, 32'h0083_0000, 1'b1, 4'd3},
    '{4'd2,  5'h11, 16'd200, 32'h0042_0000, 1'b0, 4'd2},
    '{4'd3,  5'h10, 16'd5,   32'h0083_0000, 1'b0, 4'd3},
    '{4'd0,  5'h11, 16'd7,   32'h0023_0000, 1'b1, 4'd3},
    '{4'hF,  5'h12, 16'd2,   32'h0013_0000, 1'b0, 4'd3}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic run_vec(input vec_t v, output int wen_cnt);
    int guard;
    wen_cnt = 0;
    @(negedge clk);
    ltssm_i = 5'h03; link_stat_i = v.stat; tgt_speed_i = v.tgt; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    guard = 0;
    while (!train_en_o && guard < 20) begin
      if (ro_wen_o) wen_cnt++;
      @(negedge clk);
      guard++;
    end
    repeat (int'(v.dly)) @(negedge clk);
    ltssm_i = v.lt;
    guard = 0;
    while (busy_o && guard < 400) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
  endtask

  initial begin
    int wen;
    int g;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy_o, 0);
    chk("R1 flags", {link_up_o, timeout_o, already_up_o, ro_wen_o, train_en_o}, 0);
    chk("R1 speed/width", {cur_speed_o, cur_width_o}, 0);
    chk("R1 cap", cap_word_o, CAP_R);
    chk("R1 ctl2", ctl2_word_o, CTL2_R);
    chk("R1 wsc", wsc_word_o, WSC_R & ~32'h0002_0000);

    for (int i = 0; i < NV; i++) begin
      run_vec(VEC[i], wen);
      chk("R2 unlock cycles", wen, 3);
      chk("R3 R4 cap", cap_word_o, {CAP_R[31:4], VEC[i].exp_nib});
      chk("R3 R4 ctl2", ctl2_word_o, {CTL2_R[31:4], VEC[i].exp_nib});
      chk("R6 R7 link up", link_up_o, VEC[i].exp_up);
      chk("R7 timeout", timeout_o, !VEC[i].exp_up);
      chk("R6 speed", cur_speed_o, VEC[i].exp_up ? VEC[i].stat[19:16] : 4'd0);
      chk("R6 width", cur_width_o, VEC[i].exp_up ? VEC[i].stat[23:20] : 4'd0);
      chk("R5 train enable", train_en_o, VEC[i].exp_up);
      chk("R10 speed change bit", wsc_word_o[17], VEC[i].exp_up);
      chk("R10 wsc other bits", wsc_word_o & ~32'h0002_0000, WSC_R & ~32'h0002_0000);
    end

    // R8: link already active at start (last vector left cap nibble 3)
    @(negedge clk);
    ltssm_i = 5'h11; tgt_speed_i = 4'd1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R8 already up", already_up_o, 1);
    chk("R8 not busy", busy_o, 0);
    chk("R8 timeout cleared R9", timeout_o, 0);
    repeat (6) begin
      @(negedge clk);
      chk("R8 no unlock", ro_wen_o, 0);
    end
    chk("R8 no training", train_en_o, 0);
    chk("R8 cap unchanged", cap_word_o, {CAP_R[31:4], 4'd3});
    chk("R9 already sticky", already_up_o, 1);

    // R9: a new start clears already-up; a start during the wait is ignored
    ltssm_i = 5'h03; tgt_speed_i = 4'd2; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R9 already cleared", already_up_o, 0);
    g = 0;
    while (!train_en_o && g < 20) begin @(negedge clk); g++; end
    repeat (3) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) begin
      @(negedge clk);
      chk("R9 busy start ignored", {ro_wen_o, train_en_o}, 2'b01);
    end
    ltssm_i = 5'h11;
    g = 0;
    while (busy_o && g < 400) begin @(negedge clk); g++; end
    @(negedge clk);
    chk("R9 up after ignored start", link_up_o, 1);
    ltssm_i = 5'h04;
    repeat (5) @(negedge clk);
    chk("R9 link-up sticky", link_up_o, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule